// File: doc/BRIEF.md
# USB Host Controller Interrupt Aggregator

This block collects event pulses raised by other parts of a USB host controller, latches them in a status word, and drives one level-sensitive interrupt line toward the system. Software reaches it through a small 32-bit register port with three word offsets. The first reads the pending events and clears them one bit at a time. The second turns enable bits on. The third turns enable bits off.

Bit 31 of the enable word is a global gate. While it is clear, no pending event reaches the interrupt line. The line, like the read data, is a flop output, so it responds one clock after whatever caused it. When a hardware event and a software acknowledge hit the same status bit in the same cycle, the event is kept so that it is not lost.

Top module: `hc_irq_aggregator`

## Requirements
- R1: A pulse on `evt_i[k]` sets status bit k for k in {0,1,2,3,4,5,6,30}. Pulses on any other position have no effect, and those status bits always read 0.
- R2: A write at word offset 0 clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R3: If an event pulse and a status-clear write hit the same bit in one cycle, that bit ends up set.
- R4: A write at word offset 1 ORs the write data into the enable word.
- R5: A write at word offset 2 clears every enable bit whose write-data bit is 1.
- R6: Reads at offsets 1 and 2 return the same enable word. That word only holds bits 0 to 6, 30 and 31, and every other bit reads 0.
- R7: While `rst` is high at a clock edge, the status word becomes 0, the enable word becomes 0x8000_0000, and `irq_o` and `reg_rdata` become 0.
- R8: After each edge, `irq_o` is 1 exactly when enable bit 31 is set and the status word ANDed with the enable word is nonzero. Both words are taken as they stand after that same edge.
- R9: Clearing enable bit 31 forces `irq_o` low one clock later, even with enabled events pending. Setting it again raises the line one clock later.
- R10: A write at word offset 3 changes no state, and a read at offset 3 returns 0.
- R11: `reg_rdata` is registered. The word selected by `reg_addr` at an edge, taken as it stood before that edge, appears after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset: 0 status, 1 enable-set, 2 enable-clear, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset presented at the last edge |
| irq_o | output | 1 | Level interrupt request |

## Verification
Both results of this block are due exactly one clock edge after their cause. The interrupt line reflects the status and enable words as they were updated at that same edge. The read data reflects the selected word as it stood just before that edge. The bench applies each stimulus shortly after a rising edge and advances its behavioural model at the next edge. It then compares `irq_o` and `reg_rdata` a couple of nanoseconds later, so every comparison lands in the single cycle where the result is defined.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned OFS_W  = 2;

  // Event source bit positions (bit order is decoded by software)
  localparam int unsigned SRC_SCHED_OVR  = 0;
  localparam int unsigned SRC_DONE_WB    = 1;
  localparam int unsigned SRC_FRAME_ST   = 2;
  localparam int unsigned SRC_RESUME     = 3;
  localparam int unsigned SRC_FATAL      = 4;
  localparam int unsigned SRC_FNUM_WRAP  = 5;
  localparam int unsigned SRC_HUB_CHG    = 6;
  localparam int unsigned SRC_OWNER_CHG  = 30;
  localparam int unsigned GATE_POS       = 31;

  localparam logic [REG_W-1:0] SRC_MASK_DEF =
      (REG_W'(1) << SRC_SCHED_OVR) | (REG_W'(1) << SRC_DONE_WB)  |
      (REG_W'(1) << SRC_FRAME_ST)  | (REG_W'(1) << SRC_RESUME)   |
      (REG_W'(1) << SRC_FATAL)     | (REG_W'(1) << SRC_FNUM_WRAP)|
      (REG_W'(1) << SRC_HUB_CHG)   | (REG_W'(1) << SRC_OWNER_CHG);

  typedef enum logic [OFS_W-1:0] {
    OFS_STATUS = 2'd0,
    OFS_EN_SET = 2'd1,
    OFS_EN_CLR = 2'd2,
    OFS_SPARE  = 2'd3
  } irq_ofs_e;

endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
  parameter int unsigned        DATA_W   = 32,
  parameter logic [DATA_W-1:0]  SRC_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] stat_nxt
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // event has priority over a same-cycle acknowledge
    assign stat_nxt[i] = SRC_MASK[i] &
                         (evt[i] | (stat_q[i] & ~(clr_we & clr_data[i])));

    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= stat_nxt[i];
    end
  end

endmodule

// File: rtl/hc_irq_enable.sv
module hc_irq_enable #(
  parameter int unsigned        DATA_W  = 32,
  parameter logic [DATA_W-1:0]  EN_MASK = '1,
  parameter logic [DATA_W-1:0]  EN_RST  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] en_nxt
);

  always_comb begin
    en_nxt = en_q;
    if (set_we)      en_nxt = (en_q | wdata) & EN_MASK;
    else if (clr_we) en_nxt = en_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= EN_RST;
    else     en_q <= en_nxt;
  end

endmodule

// File: rtl/hc_irq_out.sv
module hc_irq_out
  import hc_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GATE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] en_q,
  input  logic [DATA_W-1:0] stat_nxt,
  input  logic [DATA_W-1:0] en_nxt,
  input  logic [OFS_W-1:0]  addr,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata
);

  logic              irq_nxt;
  logic [DATA_W-1:0] rd_mux;

  // evaluated on the next-state words so the line moves at the same edge
  assign irq_nxt = en_nxt[GATE_BIT] & (|(stat_nxt & en_nxt));

  always_comb begin
    unique case (irq_ofs_e'(addr))
      OFS_STATUS:             rd_mux = stat_q;
      OFS_EN_SET, OFS_EN_CLR: rd_mux = en_q;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      rdata <= '0;
    end else begin
      irq_o <= irq_nxt;
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/hc_irq_aggregator.sv
module hc_irq_aggregator
  import hc_irq_pkg::*;
#(
  parameter int unsigned        DATA_W   = REG_W,
  parameter logic [DATA_W-1:0]  SRC_MASK = SRC_MASK_DEF,
  parameter int unsigned        GATE_BIT = GATE_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] GATE_ONE = DATA_W'(1) << GATE_BIT;
  localparam logic [DATA_W-1:0] EN_MASK  = SRC_MASK | GATE_ONE;

  logic              wr_stat, wr_set, wr_clr;
  logic [DATA_W-1:0] stat_q, stat_nxt, en_q, en_nxt;

  assign wr_stat = reg_we && (irq_ofs_e'(reg_addr) == OFS_STATUS);
  assign wr_set  = reg_we && (irq_ofs_e'(reg_addr) == OFS_EN_SET);
  assign wr_clr  = reg_we && (irq_ofs_e'(reg_addr) == OFS_EN_CLR);

  hc_irq_status #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_status (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .clr_we   (wr_stat),
    .clr_data (reg_wdata),
    .stat_q   (stat_q),
    .stat_nxt (stat_nxt)
  );

  hc_irq_enable #(.DATA_W(DATA_W), .EN_MASK(EN_MASK), .EN_RST(GATE_ONE)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_set),
    .clr_we (wr_clr),
    .wdata  (reg_wdata),
    .en_q   (en_q),
    .en_nxt (en_nxt)
  );

  hc_irq_out #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .stat_nxt (stat_nxt),
    .en_nxt   (en_nxt),
    .addr     (reg_addr),
    .irq_o    (irq_o),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/hc_irq_aggregator_chk.sv
module hc_irq_aggregator_chk
  import hc_irq_pkg::*;
#(
  parameter int unsigned        DATA_W   = REG_W,
  parameter logic [DATA_W-1:0]  SRC_MASK = SRC_MASK_DEF,
  parameter int unsigned        GATE_BIT = GATE_POS
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] evt_i,
  input logic              reg_we,
  input logic [OFS_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq_o
);

  localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << GATE_BIT);

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & SRC_MASK)) |=> ((stat_q & $past(evt_i & SRC_MASK)) == $past(evt_i & SRC_MASK)));

  assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~SRC_MASK) == '0);

  assert_wr_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0 && ((evt_i & reg_wdata) == '0))
      |=> ((stat_q & $past(reg_wdata)) == '0));

  assert_evt_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0 && (|(evt_i & reg_wdata & SRC_MASK)))
      |=> ((stat_q & $past(evt_i & reg_wdata & SRC_MASK)) == $past(evt_i & reg_wdata & SRC_MASK)));

  assert_en_set_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd1)
      |=> ((en_q & $past(reg_wdata & EN_MASK)) == $past(reg_wdata & EN_MASK)));

  assert_en_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2) |=> ((en_q & $past(reg_wdata)) == '0));

  assert_en_range_R6: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~EN_MASK) == '0);

  assert_irq_line_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (en_q[GATE_BIT] && ((stat_q & en_q) != '0)));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2 && reg_wdata[GATE_BIT]) |=> !irq_o);

  assert_spare_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd3 && evt_i == '0) |=> ($stable(stat_q) && $stable(en_q)));

endmodule

bind hc_irq_aggregator hc_irq_aggregator_chk #(
  .DATA_W(DATA_W), .SRC_MASK(SRC_MASK), .GATE_BIT(GATE_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .stat_q    (stat_q),
  .en_q      (en_q),
  .irq_o     (irq_o)
);

// File: tb/hc_irq_aggregator_tb.sv
module hc_irq_aggregator_tb;

  localparam logic [31:0] IMPL = 32'h4000_007F;
  localparam logic [31:0] GATE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_i = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string tag = "R7";

  logic [31:0] m_stat = '0;
  logic [31:0] m_en   = GATE;
  logic [31:0] m_rd   = '0;
  logic        m_irq  = 1'b0;

  always #5 clk = ~clk;

  hc_irq_aggregator u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one clock: update the model at the edge, compare shortly after
  task automatic step();
    logic [31:0] clr;
    @(posedge clk);
    if (rst) begin
      m_stat = '0; m_en = GATE; m_rd = '0; m_irq = 1'b0;
    end else begin
      case (reg_addr)
        2'd0:    m_rd = m_stat;
        2'd1:    m_rd = m_en;
        2'd2:    m_rd = m_en;
        default: m_rd = '0;
      endcase
      clr = (reg_we && reg_addr == 2'd0) ? reg_wdata : '0;
      m_stat = ((m_stat & ~clr) | evt_i) & IMPL;
      if (reg_we && reg_addr == 2'd1) m_en = m_en | (reg_wdata & (IMPL | GATE));
      if (reg_we && reg_addr == 2'd2) m_en = m_en & ~reg_wdata;
      m_irq = m_en[31] && ((m_stat & m_en) != 0);
    end
    #2;
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    check({tag, " rdata"}, reg_rdata, m_rd);
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d, input logic [31:0] e);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_i = e;
    step();
    reg_we = 1'b0; reg_wdata = '0; evt_i = '0;
  endtask

  task automatic rd(input logic [1:0] a);
    drive(1'b0, a, '0, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    tag = "R7";
    repeat (3) step();
    rst = 1'b0;
    rd(2'd0); rd(2'd1);

    tag = "R1";
    drive(1'b0, 2'd0, '0, 32'hFFFF_FFFF);
    rd(2'd0);
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 2'd0, '0, 32'd1 << i);
      rd(2'd0);
      drive(1'b1, 2'd0, 32'd1 << i, '0);
    end

    tag = "R2";
    drive(1'b0, 2'd0, '0, 32'h4000_005A);
    drive(1'b1, 2'd0, 32'h0000_0012, '0);
    rd(2'd0);
    drive(1'b1, 2'd0, 32'h0000_0000, '0);
    rd(2'd0);

    tag = "R3";
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0041);
    rd(2'd0);

    tag = "R4";
    drive(1'b1, 2'd1, 32'h0000_0004, '0);
    rd(2'd1);
    drive(1'b1, 2'd1, 32'h0000_0002, '0);
    tag = "R6";
    rd(2'd1); rd(2'd2);
    drive(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
    rd(2'd1); rd(2'd2);

    tag = "R5";
    drive(1'b1, 2'd2, 32'h4000_003F, '0);
    rd(2'd2);

    tag = "R8";
    drive(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    drive(1'b1, 2'd2, 32'h7FFF_FFFF, '0);
    drive(1'b1, 2'd1, 32'h0000_0004, '0);
    drive(1'b0, 2'd0, '0, 32'h0000_0008);
    drive(1'b0, 2'd0, '0, 32'h0000_0004);
    rd(2'd0);
    drive(1'b1, 2'd0, 32'h0000_0004, '0);
    rd(2'd0);

    tag = "R9";
    drive(1'b0, 2'd0, '0, 32'h0000_0004);
    drive(1'b1, 2'd2, GATE, '0);
    rd(2'd1);
    drive(1'b1, 2'd1, GATE, '0);
    rd(2'd0);

    tag = "R10";
    drive(1'b1, 2'd3, 32'hFFFF_FFFF, '0);
    rd(2'd3); rd(2'd0); rd(2'd1);

    tag = "R11";
    drive(1'b1, 2'd1, 32'h0000_0020, 32'h0000_0020);
    drive(1'b1, 2'd0, 32'h0000_0020, '0);
    rd(2'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule